// File: doc/BRIEF.md
# Memory Fill ECC Error Logger

This block sits on the path where cache-fill data returns from system memory. Each fill beat is a 128-bit subblock made of two 64-bit quadwords, and each quadword arrives with its own 8 check bits. For both quadwords the block forms an 8-bit syndrome and presents corrected data combinationally. It classifies each quadword as clean, correctable or uncorrectable.

When an error is seen, the block's reaction depends on how the errored data was used:

- **Unused quadword.** The error is logged and the corrected-read-data interrupt is raised.
- **Quadword consumed by a non-speculative load.** The block also requests a one-cycle scrub of the 64-byte block and signals a retry of the load.
- **Quadword consumed by a speculative load.** Only the interrupt is raised.

Logging keeps the first error that arrives. The status, address and both syndromes stay frozen until software clears them with a write-one-to-clear pulse. Any error that arrives while the log is frozen sets a sticky overflow bit.

Top module: `fill_ecc_logger`

## Requirements
- R1: Quadword q occupies `fill_data[64q+63:64q]` and `fill_check[8q+7:8q]`. Each data bit i takes the Hamming position that is the i-th number counted upward from 3, skipping powers of two, so positions run from 3 to 71. Check bit j (j = 0 to 6) is the XOR of the data bits whose position has bit j set. Check bit 7 is the even parity of the 64 data bits and check bits 0 to 6. When the syndrome is correctable, `corr_data` equals `fill_data` with the data bit at the syndrome's position inverted. In every other case `corr_data` equals `fill_data`.
- R2: Syndrome bits [6:0] are the recomputed check bits XOR the received check bits 0 to 6. Syndrome bit 7 is the XOR of all 72 received bits. A syndrome is correctable when bit 7 is 1 and bits [6:0] are at most 71. Any other nonzero syndrome is uncorrectable.
- R3: A fill error is logged unless it is speculative (defined in R10). When a logged correctable error arrives and the log is empty, then one cycle later:
  - `st_dmem_err` is 1;
  - `log_addr` equals `fill_pa[42:6]`;
  - `log_syn0` and `log_syn1` hold the syndromes of quadword 0 and quadword 1.
- R4: A logged uncorrectable error sets `st_uncorr` and captures the address and syndromes in the same way as R3. A fill that contains an uncorrectable quadword raises no scrub request and no load retry.
- R5: While `st_dmem_err` or `st_uncorr` is 1, a further logged error leaves the address, syndromes and status bits unchanged and sets `st_ovf`.
- R6: A `csr_clr` pulse clears `st_dmem_err`, `st_uncorr`, `st_ovf` and `crd_irq` on the next edge. A logged error in the same cycle is then captured into the emptied log.
- R7: `crd_irq` becomes 1 one cycle after any fill with a correctable quadword while `crd_en` is 1, and stays 1 until `csr_clr` pulses or `crd_en` is 0. While `crd_en` is 0, `crd_irq` is 0.
- R8: An errored quadword whose bit in `fill_ld_qw` is 0 is logged and raises the interrupt, but causes no `scrub_req` and no `load_retry`.
- R9: A correctable error on a quadword marked in `fill_ld_qw`, with `fill_spec` low and no uncorrectable quadword in the fill, makes `load_retry` pulse for one cycle on the next cycle. In the same situation `scrub_req` pulses for one cycle with `scrub_addr` equal to `fill_pa[42:6]`, subject to R11.
- R10: A fill is speculative when `fill_spec` is 1 and an errored quadword is marked in `fill_ld_qw`. A speculative fill with a correctable error raises only the interrupt: status, address and syndromes stay unchanged, and there is no scrub request and no retry.
- R11: After a `scrub_req`, the scrub stays pending until a cycle with `scrub_ack` high. Requests that qualify under R9 while the scrub is pending produce no `scrub_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | A fill subblock is present this cycle |
| fill_pa | input | 43 | Physical address of the fill |
| fill_data | input | 128 | Two quadwords, quadword 0 in the low half |
| fill_check | input | 16 | Check bits, quadword 0 in the low byte |
| fill_ld_qw | input | 2 | Quadwords consumed by the pending load |
| fill_spec | input | 1 | The consuming load is speculative |
| corr_data | output | 128 | Corrected data, combinational |
| crd_en | input | 1 | Corrected-read-data interrupt enable |
| csr_clr | input | 1 | Write-one-to-clear pulse for status and interrupt |
| st_dmem_err | output | 1 | Correctable fill error logged |
| st_uncorr | output | 1 | Uncorrectable fill error logged |
| st_ovf | output | 1 | Error arrived while the log was frozen |
| log_addr | output | 37 | Logged block address bits [42:6] |
| log_syn0 | output | 8 | Logged syndrome of quadword 0 |
| log_syn1 | output | 8 | Logged syndrome of quadword 1 |
| crd_irq | output | 1 | Corrected-read-data interrupt, level |
| scrub_ack | input | 1 | Pending scrub has been accepted |
| scrub_req | output | 1 | One-cycle scrub request |
| scrub_addr | output | 37 | Block address of the scrub |
| load_retry | output | 1 | One-cycle retry of the consuming load |

## Verification
The bench builds the block with its default parameters: a 43-bit physical address and block offset 6, which gives a 37-bit logged block address. Random addresses therefore reach the top address bit, and the bench checks that the log and the scrub address cut the address at bit 6. Injected flips land anywhere among the 72 bits of either quadword, including the check bits and the overall parity bit. Single, double and mixed fills, together with random use masks, speculation, clears, enables and acknowledgements, exercise every routing decision and the scrub hold-off.

// File: rtl/fill_ecc_pkg.sv
// Shared constants and elaboration-time functions for the fill ECC logger.
// Assumes a 64-bit quadword with a 7-bit Hamming code plus overall parity.
package fill_ecc_pkg;
    localparam int QW_W   = 64;
    localparam int CHK_W  = 8;
    localparam int HAM_W  = CHK_W - 1;
    localparam int NUM_QW = 2;

    // Hamming position of data bit idx: idx-th non-power-of-two from 3.
    function automatic int hpos(input int idx);
        int n;
        int r;
        n = 0;
        r = 0;
        for (int c = 3; c < 128; c++) begin
            if ((c & (c - 1)) != 0) begin
                if (n == idx && r == 0) r = c;
                n++;
            end
        end
        return r;
    endfunction

    localparam int MAX_POS = hpos(QW_W - 1);

    // Mask of data bits that feed Hamming check bit j.
    function automatic logic [QW_W-1:0] col_mask(input int j);
        logic [QW_W-1:0] m;
        int p;
        m = '0;
        for (int i = 0; i < QW_W; i++) begin
            p = hpos(i);
            m[i] = p[j];
        end
        return m;
    endfunction
endpackage

// File: rtl/fill_qw_dec.sv
// Syndrome generation and single-bit correction for one quadword.
// Purely combinational; assumes the code defined in fill_ecc_pkg.
module fill_qw_dec
    import fill_ecc_pkg::*;
(
    input  logic [QW_W-1:0]  data,
    input  logic [CHK_W-1:0] check,
    output logic [CHK_W-1:0] syn,
    output logic             ce,
    output logic             ue,
    output logic [QW_W-1:0]  corr
);
    logic [HAM_W-1:0] recal;

    // Recompute each Hamming check bit from its constant column mask.
    for (genvar j = 0; j < HAM_W; j++) begin : g_col
        localparam logic [QW_W-1:0] MASK = col_mask(j);
        assign recal[j] = ^(data & MASK);
    end

    assign syn = {^{data, check}, recal ^ check[HAM_W-1:0]};
    assign ce  = syn[CHK_W-1] && (syn[HAM_W-1:0] <= MAX_POS[HAM_W-1:0]);
    assign ue  = (syn != '0) && !ce;

    // Invert the one data bit whose position matches the syndrome.
    for (genvar i = 0; i < QW_W; i++) begin : g_fix
        localparam int P = hpos(i);
        assign corr[i] = data[i] ^ (ce && (syn[HAM_W-1:0] == P[HAM_W-1:0]));
    end

    // Classification and correction sanity, guarded against unknown inputs.
    always_comb begin
        if (!$isunknown({data, check})) begin
            a_r2_ce_ue_exclusive: assert (!(ce && ue));
            a_r1_at_most_one_flip: assert ($countones(corr ^ data) <= 1);
            a_r2_ue_no_change: assert (ce || (corr == data));
        end
    end
endmodule

// File: rtl/fill_err_log.sv
// First-error-wins capture of fill error status, address and syndromes,
// plus the level corrected-read-data interrupt. Events arrive pre-qualified.
module fill_err_log
    import fill_ecc_pkg::*;
#(
    parameter int BA_W = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_log,
    input  logic             ev_ce,
    input  logic             ev_ue,
    input  logic             ev_crd,
    input  logic [BA_W-1:0]  ev_addr,
    input  logic [CHK_W-1:0] ev_syn0,
    input  logic [CHK_W-1:0] ev_syn1,
    input  logic             crd_en,
    input  logic             csr_clr,
    output logic             st_dmem_err,
    output logic             st_uncorr,
    output logic             st_ovf,
    output logic [BA_W-1:0]  log_addr,
    output logic [CHK_W-1:0] log_syn0,
    output logic [CHK_W-1:0] log_syn1,
    output logic             crd_irq
);
    logic frozen;
    assign frozen = (st_dmem_err || st_uncorr) && !csr_clr;

    // Status, overflow and captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_dmem_err <= 1'b0;
            st_uncorr   <= 1'b0;
            st_ovf      <= 1'b0;
            log_addr    <= '0;
            log_syn0    <= '0;
            log_syn1    <= '0;
        end else begin
            if (csr_clr) begin
                st_dmem_err <= 1'b0;
                st_uncorr   <= 1'b0;
                st_ovf      <= 1'b0;
            end
            if (ev_log) begin
                if (frozen) begin
                    st_ovf <= 1'b1;
                end else begin
                    st_dmem_err <= ev_ce;
                    st_uncorr   <= ev_ue;
                    log_addr    <= ev_addr;
                    log_syn0    <= ev_syn0;
                    log_syn1    <= ev_syn1;
                end
            end
        end
    end

    // Level interrupt: set wins, cleared by software or by disabling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crd_irq <= 1'b0;
        end else if (ev_crd && crd_en) begin
            crd_irq <= 1'b1;
        end else if (csr_clr || !crd_en) begin
            crd_irq <= 1'b0;
        end
    end

    a_r5_log_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_dmem_err || st_uncorr) && !csr_clr) |=>
        ($stable(log_addr) && $stable(log_syn0) && $stable(log_syn1)));
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !crd_en |=> !crd_irq);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_clr && !ev_log && !ev_crd) |=> (!st_dmem_err && !st_uncorr && !st_ovf && !crd_irq));
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovf && !csr_clr) |=> st_ovf);
endmodule

// File: rtl/fill_scrub_ctl.sv
// Issues single-cycle scrub requests and load retries for load-consumed
// correctable errors; holds off new scrubs until the pending one is acked.
module fill_scrub_ctl #(
    parameter int BA_W = 37
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want_scrub,
    input  logic [BA_W-1:0] blk_addr,
    input  logic            scrub_ack,
    output logic            scrub_req,
    output logic [BA_W-1:0] scrub_addr,
    output logic            load_retry
);
    logic pend_q;

    // Pending tracker and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            scrub_req  <= 1'b0;
            scrub_addr <= '0;
        end else begin
            scrub_req <= 1'b0;
            if (pend_q) begin
                if (scrub_ack) pend_q <= 1'b0;
            end else if (want_scrub) begin
                pend_q     <= 1'b1;
                scrub_req  <= 1'b1;
                scrub_addr <= blk_addr;
            end
        end
    end

    // Retry pulse for the consuming load.
    always_ff @(posedge clk) begin
        if (!rst_n) load_retry <= 1'b0;
        else        load_retry <= want_scrub;
    end

    a_r9_scrub_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req |=> !scrub_req);
    a_r11_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !scrub_ack) |=> !scrub_req);
    a_r9_req_implies_retry: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req |-> load_retry);
endmodule

// File: rtl/fill_ecc_logger.sv
// Top: decodes both quadwords of a fill subblock, routes errors by how the
// data was used (unused, load, speculative load) to logging and scrubbing.
module fill_ecc_logger
    import fill_ecc_pkg::*;
#(
    parameter int PA_W    = 43,
    parameter int BLK_LSB = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fill_valid,
    input  logic [PA_W-1:0]           fill_pa,
    input  logic [NUM_QW*QW_W-1:0]    fill_data,
    input  logic [NUM_QW*CHK_W-1:0]   fill_check,
    input  logic [NUM_QW-1:0]         fill_ld_qw,
    input  logic                      fill_spec,
    output logic [NUM_QW*QW_W-1:0]    corr_data,
    input  logic                      crd_en,
    input  logic                      csr_clr,
    output logic                      st_dmem_err,
    output logic                      st_uncorr,
    output logic                      st_ovf,
    output logic [PA_W-BLK_LSB-1:0]   log_addr,
    output logic [CHK_W-1:0]          log_syn0,
    output logic [CHK_W-1:0]          log_syn1,
    output logic                      crd_irq,
    input  logic                      scrub_ack,
    output logic                      scrub_req,
    output logic [PA_W-BLK_LSB-1:0]   scrub_addr,
    output logic                      load_retry
);
    localparam int BA_W = PA_W - BLK_LSB;

    logic [CHK_W-1:0]  syn [NUM_QW];
    logic [NUM_QW-1:0] ce, ue, errm;
    logic              any_ce, any_ue, spec_hit, ev_log, want_scrub;
    logic [BA_W-1:0]   blk_addr;

    // One decoder per quadword.
    for (genvar q = 0; q < NUM_QW; q++) begin : g_qw
        fill_qw_dec u_dec (
            .data  (fill_data[q*QW_W +: QW_W]),
            .check (fill_check[q*CHK_W +: CHK_W]),
            .syn   (syn[q]),
            .ce    (ce[q]),
            .ue    (ue[q]),
            .corr  (corr_data[q*QW_W +: QW_W])
        );
    end

    assign errm       = ce | ue;
    assign any_ce     = fill_valid && (|ce);
    assign any_ue     = fill_valid && (|ue);
    assign spec_hit   = fill_spec && (|(errm & fill_ld_qw));
    assign ev_log     = (any_ce || any_ue) && !spec_hit;
    assign want_scrub = fill_valid && !fill_spec && (|(ce & fill_ld_qw)) && !(|ue);
    assign blk_addr   = fill_pa[PA_W-1:BLK_LSB];

    fill_err_log #(.BA_W(BA_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_log     (ev_log),
        .ev_ce      (any_ce),
        .ev_ue      (any_ue),
        .ev_crd     (any_ce),
        .ev_addr    (blk_addr),
        .ev_syn0    (syn[0]),
        .ev_syn1    (syn[1]),
        .crd_en     (crd_en),
        .csr_clr    (csr_clr),
        .st_dmem_err(st_dmem_err),
        .st_uncorr  (st_uncorr),
        .st_ovf     (st_ovf),
        .log_addr   (log_addr),
        .log_syn0   (log_syn0),
        .log_syn1   (log_syn1),
        .crd_irq    (crd_irq)
    );

    fill_scrub_ctl #(.BA_W(BA_W)) u_scrub (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_scrub (want_scrub),
        .blk_addr   (blk_addr),
        .scrub_ack  (scrub_ack),
        .scrub_req  (scrub_req),
        .scrub_addr (scrub_addr),
        .load_retry (load_retry)
    );

    a_r10_spec_no_scrub: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_spec) |=> (!scrub_req && !load_retry));
    a_r4_ue_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && (|ue)) |=> !load_retry);
    a_r8_unused_no_scrub: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && (fill_ld_qw == '0)) |=> (!scrub_req && !load_retry));
endmodule

// File: tb/fill_ecc_logger_bench.sv
`timescale 1ns/1ps
module fill_ecc_logger_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fill_valid = 1'b0;
    logic [42:0]  fill_pa = '0;
    logic [127:0] fill_data = '0;
    logic [15:0]  fill_check = '0;
    logic [1:0]   fill_ld_qw = '0;
    logic         fill_spec = 1'b0;
    logic         crd_en = 1'b0;
    logic         csr_clr = 1'b0;
    logic         scrub_ack = 1'b0;
    logic [127:0] corr_data;
    logic         st_dmem_err, st_uncorr, st_ovf, crd_irq, scrub_req, load_retry;
    logic [36:0]  log_addr, scrub_addr;
    logic [7:0]   log_syn0, log_syn1;

    fill_ecc_logger u_fill_ecc_logger (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int pos_tab [64];

    // Bench model state
    bit m_dm, m_ue, m_ovf, m_irq, m_pend, m_req, m_retry;
    logic [36:0] m_addr, m_saddr;
    logic [7:0]  m_s0, m_s1;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] b_enc(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 7; j++)
                if (pos_tab[i][j]) c[j] ^= d[i];
        c[7] = ^{d, c[6:0]};
        return c;
    endfunction

    function automatic logic [7:0] b_syn(input logic [63:0] d, input logic [7:0] c);
        logic [7:0] e = b_enc(d);
        return {^{d, c}, e[6:0] ^ c[6:0]};
    endfunction

    function automatic bit b_ce(input logic [7:0] s);
        return s[7] && (s[6:0] <= 7'd71);
    endfunction

    function automatic logic [63:0] b_fix(input logic [63:0] d, input logic [7:0] s);
        logic [63:0] r = d;
        if (b_ce(s))
            for (int i = 0; i < 64; i++)
                if (pos_tab[i] == int'(s[6:0])) r[i] = ~r[i];
        return r;
    endfunction

    // Build a quadword with nflip distinct bit errors among its 72 bits.
    task automatic make_qw(input logic [63:0] d, input int nflip, input int b0, input int b1,
                           output logic [63:0] od, output logic [7:0] oc);
        logic [71:0] w = {b_enc(d), d};
        if (nflip >= 1) w[b0] = ~w[b0];
        if (nflip >= 2) w[b1] = ~w[b1];
        od = w[63:0];
        oc = w[71:64];
    endtask

    task automatic compare_regs(input string t);
        chk({t, " R3/R4 st_dmem_err"}, 128'(st_dmem_err), 128'(m_dm));
        chk({t, " R4 st_uncorr"}, 128'(st_uncorr), 128'(m_ue));
        chk({t, " R5 st_ovf"}, 128'(st_ovf), 128'(m_ovf));
        chk({t, " R3/R5 log_addr"}, 128'(log_addr), 128'(m_addr));
        chk({t, " R3/R5 log_syn"}, 128'({log_syn1, log_syn0}), 128'({m_s1, m_s0}));
        chk({t, " R7 crd_irq"}, 128'(crd_irq), 128'(m_irq));
        chk({t, " R9/R11 scrub_req"}, 128'(scrub_req), 128'(m_req));
        if (m_req) chk({t, " R9 scrub_addr"}, 128'(scrub_addr), 128'(m_saddr));
        chk({t, " R9 load_retry"}, 128'(load_retry), 128'(m_retry));
    endtask

    // One cycle: drive at negedge, check combinational output, predict, check registers.
    task automatic step(input string t, input bit v, input logic [42:0] pa,
                        input logic [127:0] d, input logic [15:0] c, input logic [1:0] ld,
                        input bit sp, input bit en, input bit clr, input bit ack);
        logic [7:0] s0, s1;
        bit ce0, ce1, ue0, ue1, anyce, anyue, shit, lg, fr, ws;
        logic [1:0] errm, cem;
        @(negedge clk);
        fill_valid = v; fill_pa = pa; fill_data = d; fill_check = c;
        fill_ld_qw = ld; fill_spec = sp; crd_en = en; csr_clr = clr; scrub_ack = ack;
        #1;
        s0 = b_syn(d[63:0], c[7:0]);
        s1 = b_syn(d[127:64], c[15:8]);
        chk({t, " R1/R2 corr_data"}, corr_data, {b_fix(d[127:64], s1), b_fix(d[63:0], s0)});
        ce0 = b_ce(s0); ce1 = b_ce(s1);
        ue0 = (s0 != 0) && !ce0; ue1 = (s1 != 0) && !ce1;
        anyce = v && (ce0 || ce1);
        anyue = v && (ue0 || ue1);
        errm  = {ce1 || ue1, ce0 || ue0};
        cem   = {ce1, ce0};
        shit  = sp && ((errm & ld) != 0);
        lg    = (anyce || anyue) && !shit;
        fr    = (m_dm || m_ue) && !clr;
        if (clr) begin m_dm = 0; m_ue = 0; m_ovf = 0; end
        if (lg) begin
            if (fr) m_ovf = 1;
            else begin
                m_dm = anyce; m_ue = anyue; m_addr = pa[42:6]; m_s0 = s0; m_s1 = s1;
            end
        end
        if (anyce && en) m_irq = 1;
        else if (clr || !en) m_irq = 0;
        ws = v && !sp && ((cem & ld) != 0) && !(ue0 || ue1);
        m_retry = ws;
        if (m_pend) begin
            m_req = 0;
            if (ack) m_pend = 0;
        end else if (ws) begin
            m_req = 1; m_pend = 1; m_saddr = pa[42:6];
        end else m_req = 0;
        @(posedge clk);
        #1;
        compare_regs(t);
    endtask

    // Convenience: fill with chosen flips per quadword.
    task automatic fill(input string t, input logic [42:0] pa, input int f0, input int b0,
                        input int f1, input int b1, input logic [1:0] ld, input bit sp,
                        input bit en, input bit clr, input bit ack);
        logic [63:0] d0, d1;
        logic [7:0] c0, c1;
        make_qw({$urandom, $urandom}, f0, b0, (b0 + 5) % 72, d0, c0);
        make_qw({$urandom, $urandom}, f1, b1, (b1 + 9) % 72, d1, c1);
        step(t, 1'b1, pa, {d1, d0}, {c1, c0}, ld, sp, en, clr, ack);
    endtask

    initial begin
        int dummy;
        int n;
        n = 0;
        for (int c = 3; c < 128 && n < 64; c++)
            if ((c & (c - 1)) != 0) begin pos_tab[n] = c; n++; end
        dummy = $urandom(32'h5eed_0f11);
        m_dm = 0; m_ue = 0; m_ovf = 0; m_irq = 0; m_pend = 0; m_req = 0; m_retry = 0;
        m_addr = '0; m_saddr = '0; m_s0 = '0; m_s1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_regs("reset");
        // Directed corner cases
        fill("clean", 43'h7ff_ffff_ffc0, 0, 0, 0, 0, 2'b11, 0, 1, 0, 0);
        fill("R8 unused CE qw1 data bit", 43'h400_0000_1240, 0, 0, 1, 17, 2'b01, 0, 1, 0, 0);
        fill("R5 second error overflow", 43'h123_4567_8980, 1, 3, 0, 0, 2'b00, 0, 1, 0, 0);
        step("R6 clear", 1'b0, '0, '0, '0, 2'b00, 0, 1, 1, 0);
        fill("R10 speculative load CE", 43'h0ab_cdef_0000, 1, 70, 0, 0, 2'b01, 1, 1, 1, 0);
        fill("R9 load CE check bit", 43'h555_5555_5540, 1, 64, 0, 0, 2'b01, 0, 1, 1, 0);
        fill("R11 held off while pending", 43'h2aa_aaaa_aac0, 0, 0, 1, 63, 2'b10, 0, 1, 1, 0);
        step("R11 ack", 1'b0, '0, '0, '0, 2'b00, 0, 1, 1, 1);
        fill("R9 scrub after ack", 43'h111_2222_3340, 1, 71, 0, 0, 2'b11, 0, 1, 1, 0);
        step("R11 ack2", 1'b0, '0, '0, '0, 2'b00, 0, 1, 1, 1);
        fill("R4 double error with CE", 43'h7f0_0000_0040, 2, 10, 1, 2, 2'b11, 0, 1, 1, 0);
        fill("R7 enable off", 43'h000_0000_0000, 1, 0, 0, 0, 2'b00, 0, 0, 1, 0);
        fill("R7 enable on", 43'h000_0000_0040, 1, 0, 0, 0, 2'b00, 0, 1, 1, 0);
        step("R7 disable clears", 1'b0, '0, '0, '0, 2'b00, 0, 0, 0, 0);
        // Constrained random
        for (int k = 0; k < 4000; k++) begin
            int r0, r1, f0, f1;
            r0 = int'($urandom_range(0, 99));
            r1 = int'($urandom_range(0, 99));
            f0 = (r0 < 70) ? 0 : (r0 < 95) ? 1 : 2;
            f1 = (r1 < 70) ? 0 : (r1 < 95) ? 1 : 2;
            if ($urandom_range(0, 9) == 0)
                step("rand idle", 1'b0, {$urandom, $urandom}, '0, '0, 2'($urandom), 1'($urandom),
                     $urandom_range(0, 9) != 0, $urandom_range(0, 7) == 0, 1'($urandom));
            else
                fill("rand", {$urandom, $urandom}, f0, int'($urandom_range(0, 71)),
                     f1, int'($urandom_range(0, 71)), 2'($urandom),
                     $urandom_range(0, 4) == 0, $urandom_range(0, 9) != 0,
                     $urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0);
        end
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule